// File: doc/BRIEF.md
# Row Pointer Sub-sampling Sequencer

This block drives the row address of an image sensor readout. A frame-start strobe points it at the first row to be read. Each advance strobe then moves the pointer to the next row that the selected mode keeps. Rows that the mode skips never appear on the address output.

In full mode every row of the 1024-row array is visited in order. In sub-sampling mode the array is treated as groups of four rows, and exactly two rows of each group are read. Two swap controls choose which two. One control exchanges pattern positions 1 and 2, and the other exchanges positions 3 and 0. The mode inputs are captured at frame start and stay fixed for the rest of the frame. When the last kept row has been passed, the block raises a one-cycle end-of-frame pulse, drops row-valid and holds the pointer until the next frame start.

Top module: `row_subsample_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `row_valid` = 0, `row_addr` = 0 and `frame_end` = 0.
- R2: A `frame_start` sampled at an edge gives `row_valid` = 1 in the next cycle, with `row_addr` set to the first kept row of group 0. A group is `row_addr[9:2]`, and a position within a group is `row_addr[1:0]`.
- R3: With `sub_en` = 0 at frame start, each accepted advance raises `row_addr` by exactly one, visible in the cycle after the advance edge.
- R4: With `sub_en` = 1 and no swap, only positions 0 and 1 are kept: 0, 1, 4, 5, … 1020, 1021.
- R5: With `sub_en` = 1 and only `swap12` = 1, positions 0 and 2 are kept: 0, 2, 4, 6, … 1022.
- R6: With `sub_en` = 1 and only `swap30` = 1, positions 1 and 3 are kept: 1, 3, 5, … 1023.
- R7: With `sub_en` = 1 and both swaps set, positions 2 and 3 are kept: 2, 3, 6, 7, … 1022, 1023.
- R8: When `sub_en` = 0, `swap12` and `swap30` have no effect, and all 1024 rows are visited.
- R9: Changes to `sub_en`, `swap12` or `swap30` after frame start do not alter the current frame's sequence.
- R10: An advance while `row_addr` is the last kept row gives, in the next cycle, `frame_end` = 1 for one cycle and `row_valid` = 0, with `row_addr` unchanged.
- R11: An advance while `row_valid` = 0 is ignored. When `frame_start` and `advance` are high together, the frame start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Starts a frame and samples the mode inputs |
| advance | input | 1 | Step to the next kept row |
| sub_en | input | 1 | Sub-sampling enable |
| swap12 | input | 1 | Exchange pattern positions 1 and 2 |
| swap30 | input | 1 | Exchange pattern positions 3 and 0 |
| row_addr | output | 10 | Current row pointer |
| row_valid | output | 1 | Pointer addresses a row of the current frame |
| frame_end | output | 1 | One-cycle pulse after the last row is passed |

## Verification
Every result arrives exactly one cycle after its stimulus: the pointer after an advance or frame start, and the end-of-frame pulse after the final advance. The bench drives each strobe on a falling edge and holds it for one cycle. It compares outputs on the following falling edge, after the single register stage has updated. The end pulse is checked in that window and checked again as low one cycle later. For each mode, the bench walks a whole frame and checks every address against a sequence computed from the kept-position table.

// File: rtl/row_subsample_seq.sv
module row_subsample_seq #(
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_start,
  input  logic                advance,
  input  logic                sub_en,
  input  logic                swap12,
  input  logic                swap30,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                row_valid,
  output logic                frame_end
);
  localparam int GRP_BITS = ROW_BITS - 2;

  logic [3:0]          keep_q;
  logic [ROW_BITS-1:0] row_q;
  logic                valid_q, end_q;

  function automatic logic [1:0] low_idx(input logic [3:0] m);
    if (m[0])      return 2'd0;
    else if (m[1]) return 2'd1;
    else if (m[2]) return 2'd2;
    else           return 2'd3;
  endfunction

  wire [3:0] base_m  = 4'b0011;
  wire [3:0] sw12_m  = swap12 ? {base_m[3], base_m[1], base_m[2], base_m[0]} : base_m;
  wire [3:0] sw30_m  = swap30 ? {sw12_m[0], sw12_m[2], sw12_m[1], sw12_m[3]} : sw12_m;
  wire [3:0] mode_m  = sub_en ? sw30_m : 4'hF;

  wire [1:0]          pos       = row_q[1:0];
  wire [GRP_BITS-1:0] grp       = row_q[ROW_BITS-1:2];
  wire [3:0]          upto      = (4'd2 << pos) - 4'd1;
  wire [3:0]          above     = keep_q & ~upto;
  wire                last_grp  = &grp;
  wire                at_last   = (above == 4'd0) && last_grp;
  wire [ROW_BITS-1:0] next_row  = (above != 4'd0) ? {grp, low_idx(above)}
                                                  : {grp + 1'b1, low_idx(keep_q)};

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q  <= 4'hF;
      row_q   <= '0;
      valid_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (frame_start) begin
        keep_q  <= mode_m;
        row_q   <= {{GRP_BITS{1'b0}}, low_idx(mode_m)};
        valid_q <= 1'b1;
      end else if (advance && valid_q) begin
        if (at_last) begin
          valid_q <= 1'b0;
          end_q   <= 1'b1;
        end else begin
          row_q <= next_row;
        end
      end
    end
  end

  assign row_addr  = row_q;
  assign row_valid = valid_q;
  assign frame_end = end_q;
endmodule

// File: rtl/row_subsample_seq_chk.sv
module row_subsample_seq_chk #(
  parameter int ROW_BITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_start,
  input logic                advance,
  input logic [ROW_BITS-1:0] row_addr,
  input logic                row_valid,
  input logic                frame_end,
  input logic [3:0]          keep_q
);
  logic past_rst = 1'b0;
  always_ff @(posedge clk) past_rst <= rst;

  always @(posedge clk)
    if (past_rst)
      a_r1_reset_state: assert (!row_valid && row_addr == '0 && !frame_end);

  a_r2_frame_load: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> row_valid && row_addr[ROW_BITS-1:2] == '0 && keep_q[row_addr[1:0]]);

  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    (row_valid && advance && !frame_start && keep_q == 4'hF && !(&row_addr))
      |=> row_addr == $past(row_addr) + 1'b1);

  a_r4_kept_only: assert property (@(posedge clk) disable iff (rst)
    row_valid |-> keep_q[row_addr[1:0]]);

  a_r10_end_drops_valid: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> !row_valid && $stable(row_addr));

  a_r10_end_single: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!row_valid && !frame_start) |=> $stable(row_addr) && !row_valid);

  a_r9_forward_only: assert property (@(posedge clk) disable iff (rst)
    (row_valid && advance && !frame_start) |=> (row_valid && row_addr > $past(row_addr)) || frame_end);
endmodule

bind row_subsample_seq row_subsample_seq_chk #(.ROW_BITS(ROW_BITS)) chk_i (
  .clk(clk), .rst(rst), .frame_start(frame_start), .advance(advance),
  .row_addr(row_addr), .row_valid(row_valid), .frame_end(frame_end), .keep_q(keep_q)
);

// File: tb/row_subsample_seq_tb_top.sv
`timescale 1ns/1ps
module row_subsample_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, advance = 1'b0;
  logic sub_en = 1'b0, swap12 = 1'b0, swap30 = 1'b0;
  logic [9:0] row_addr;
  logic row_valid, frame_end;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  row_subsample_seq dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .advance(advance),
    .sub_en(sub_en), .swap12(swap12), .swap30(swap30),
    .row_addr(row_addr), .row_valid(row_valid), .frame_end(frame_end)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_row(input int k, input bit s, input bit a, input bit b);
    int p0, p1;
    if (!s) return k;
    case ({a, b})
      2'b00: begin p0 = 0; p1 = 1; end
      2'b10: begin p0 = 0; p1 = 2; end
      2'b01: begin p0 = 1; p1 = 3; end
      default: begin p0 = 2; p1 = 3; end
    endcase
    return (k / 2) * 4 + ((k % 2) ? p1 : p0);
  endfunction

  task automatic step();
    @(negedge clk) advance = 1'b1;
    @(negedge clk) advance = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(row_valid == 0, "R1 valid", row_valid, 0);
    check(row_addr == 0, "R1 addr", row_addr, 0);
    check(frame_end == 0, "R1 end", frame_end, 0);
    rst = 1'b0;
  endtask

  task automatic t_frame(input bit s, input bit a, input bit b, input bit scramble, input string req);
    int n = s ? 512 : 1024;
    int last;
    @(negedge clk);
    sub_en = s; swap12 = a; swap30 = b; frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    check(row_valid == 1, "R2 valid", row_valid, 1);
    check(row_addr == exp_row(0, s, a, b), "R2 first row", row_addr, exp_row(0, s, a, b));
    if (scramble) begin sub_en = ~s; swap12 = ~a; swap30 = ~b; end
    for (int k = 1; k < n; k++) begin
      step();
      check(row_addr == exp_row(k, s, a, b) && row_valid, req, row_addr, exp_row(k, s, a, b));
    end
    last = exp_row(n - 1, s, a, b);
    step();
    check(frame_end == 1, "R10 end pulse", frame_end, 1);
    check(row_valid == 0, "R10 valid low", row_valid, 0);
    check(row_addr == last, "R10 addr hold", row_addr, last);
    @(negedge clk);
    check(frame_end == 0, "R10 pulse one cycle", frame_end, 0);
  endtask

  task automatic t_ignore_and_priority();
    step();
    check(row_valid == 0, "R11 idle advance valid", row_valid, 0);
    check(row_addr == 1023, "R11 idle advance addr", row_addr, 1023);
    check(frame_end == 0, "R11 idle advance end", frame_end, 0);
    @(negedge clk);
    sub_en = 1; swap12 = 0; swap30 = 1; frame_start = 1; advance = 1;
    @(negedge clk) begin frame_start = 0; advance = 0; end
    check(row_addr == 1 && row_valid, "R11 start wins", row_addr, 1);
  endtask

  initial begin
    t_reset();
    t_frame(0, 0, 0, 0, "R3 normal step");
    t_frame(1, 0, 0, 0, "R4 default sub");
    t_frame(1, 1, 0, 0, "R5 swap12");
    t_frame(1, 0, 1, 0, "R6 swap30");
    t_frame(1, 1, 1, 0, "R7 both swaps");
    t_frame(0, 1, 1, 0, "R8 swaps ignored");
    t_frame(1, 0, 0, 1, "R9 mid-frame mode change");
    t_frame(0, 1, 0, 1, "R9 mid-frame mode change full");
    t_ignore_and_priority();
    t_reset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule